// File: doc/BRIEF.md
# Operand Address Sequencer

This block works out where an instruction's operand lives for an 8-bit accumulator processor. When `start_i` is pulsed with an opcode, it classifies the opcode into one of thirteen addressing modes from a fixed opcode map. It then fetches the operand bytes that follow the opcode and any pointer bytes those operands name. Memory is reached through a plain synchronous read port: the block drives an address and a read strobe, and the byte returns on `mem_data_i` in the next cycle.

When the address is known, the block raises `done_o` for one cycle. In that cycle `ea_o` holds the 16-bit effective address, `pc_o` holds the program counter advanced past the consumed operand bytes, and `imm_o` or `acc_o` marks the modes that need no memory operand. `pc_i` gives the address of the first byte after the opcode. A controlling sequencer pulses `start_i`, waits for `done_o` and then takes the result.

Top module: `ea_seq`

## Requirements
- R1: Operand-free opcodes (0xFC, 0xFF, 0xEA, 0x00 and the other implied forms) issue no read. `done_o` rises in the cycle after the start edge, with `ea_o` = 0x0000, `imm_o` = `acc_o` = 0 and `pc_o` equal to `pc_i`.
- R2: The shift and rotate accumulator forms 0x0A, 0x2A, 0x4A and 0x6A issue no read. They finish in the cycle after start with `acc_o` = 1, `imm_o` = 0, `ea_o` = 0x0000 and `pc_o` = `pc_i`.
- R3: Immediate forms (for example 0xA9, 0x69, 0xC9, 0xA2, 0xA0, 0xC0) read one byte at `pc_i`. They return that byte zero-extended on `ea_o`, with `imm_o` = 1, `acc_o` = 0 and `pc_o` = `pc_i`+1.
- R4: Zero-page forms read one byte and return it as the address with the high byte zero. The X-indexed form adds X modulo 256. The Y-indexed forms 0xB6 and 0x96 add Y modulo 256 instead. `pc_o` = `pc_i`+1.
- R5: Absolute forms read the low byte at `pc_i` and then the high byte at `pc_i`+1. The X and Y variants add the index to the 16-bit address modulo 65536. `pc_o` = `pc_i`+2.
- R6: Pre-indexed indirect forms add X to the operand byte modulo 256, giving pointer z. They then read the target low byte at z and the high byte at (z+1) modulo 256. `pc_o` = `pc_i`+1.
- R7: Post-indexed indirect forms read the pointer bytes at the zero-page operand z and at (z+1) modulo 256, so the high byte for z = 0xFF comes from 0x0000. They add Y to the resulting 16-bit value modulo 65536. `pc_o` = `pc_i`+1.
- R8: Opcode 0x6C reads a 16-bit pointer p from `pc_i` (low) and `pc_i`+1 (high). It then reads the target low byte at p and the high byte at p+1 modulo 65536. `pc_o` = `pc_i`+2.
- R9: Branch forms (low five bits 10000) read one offset byte. The result is (`pc_i`+1) plus the offset taken as two's complement, modulo 65536. `pc_o` = `pc_i`+1.
- R10: Reads are issued on consecutive cycles, the first in the cycle after the start edge. Each returned byte is used in the following cycle. With n reads, `done_o` rises n+2 cycles after the start edge, and no read is issued while `done_o` is high.
- R11: `done_o` is high for exactly one cycle per operation. `start_i` is ignored from the start edge up to and including the `done_o` cycle.
- R12: While `rst_ni` is low, `done_o`, `mem_rd_o`, `imm_o` and `acc_o` are 0, and `ea_o`, `pc_o` and `mem_addr_o` are 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an address computation (sampled when idle) |
| opcode_i | input | 8 | Opcode byte |
| pc_i | input | 16 | Address of the first byte after the opcode |
| x_i | input | 8 | X index value |
| y_i | input | 8 | Y index value |
| mem_addr_o | output | 16 | Read address |
| mem_rd_o | output | 1 | Read strobe |
| mem_data_i | input | 8 | Read data, valid one cycle after the strobe |
| ea_o | output | 16 | Effective address, or the immediate byte |
| imm_o | output | 1 | Result is an immediate value |
| acc_o | output | 1 | Accumulator form, no address |
| pc_o | output | 16 | Program counter after the operand bytes |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
On every cycle, the bound checker enforces the single-cycle done pulse, the absence of reads outside an operation or during the done cycle, the mutual exclusion of the immediate and accumulator flags, the zero high byte of an immediate result, the held program counter for accumulator forms and quiet outputs during reset. The per-mode arithmetic cannot be seen from the ports alone: zero-page and 16-bit wrap points, the 0xFF-to-0x00 pointer wrap, the sign of the branch offset and the exact read address order. These are shown only by the bench scenarios, which drive chosen memory contents and compare every read address and every result against a behavioural model. The same applies to the rule that `start_i` is ignored while busy.

// File: rtl/ea_seq_pkg.sv
`timescale 1ns/1ps
package ea_seq_pkg;
  typedef enum logic [3:0] {
    M_IMP, M_ACC, M_IMM, M_ZP, M_ZPX, M_ZPY, M_ABS,
    M_ABX, M_ABY, M_IND, M_INX, M_INY, M_REL
  } amode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_OP0, S_OP1, S_OP2, S_PTR, S_TGT, S_DONE
  } state_e;
endpackage

// File: rtl/ea_mode_decode.sv
`timescale 1ns/1ps
module ea_mode_decode
  import ea_seq_pkg::*;
(
  input  logic [7:0] opcode_i,
  output amode_e     mode_o
);
  logic [1:0] grp;
  logic [2:0] col;
  logic [2:0] row;

  assign grp = opcode_i[1:0];
  assign col = opcode_i[4:2];
  assign row = opcode_i[7:5];

  always_comb begin
    mode_o = M_IMP;
    if (opcode_i == 8'hFC || opcode_i == 8'hFF) begin
      mode_o = M_IMP;
    end else if (opcode_i == 8'h6C) begin
      mode_o = M_IND;
    end else if (opcode_i == 8'h4C || opcode_i == 8'h20) begin
      mode_o = M_ABS;
    end else begin
      unique case (grp)
        2'b01: begin
          unique case (col)
            3'd0: mode_o = M_INX;
            3'd1: mode_o = M_ZP;
            3'd2: mode_o = M_IMM;
            3'd3: mode_o = M_ABS;
            3'd4: mode_o = M_INY;
            3'd5: mode_o = M_ZPX;
            3'd6: mode_o = M_ABY;
            default: mode_o = M_ABX;
          endcase
        end
        2'b10: begin
          unique case (col)
            3'd0: mode_o = (row == 3'd5) ? M_IMM : M_IMP;
            3'd1: mode_o = M_ZP;
            3'd2: mode_o = opcode_i[7] ? M_IMP : M_ACC;
            3'd3: mode_o = M_ABS;
            3'd5: mode_o = (row == 3'd4 || row == 3'd5) ? M_ZPY : M_ZPX;
            3'd7: mode_o = (row == 3'd5) ? M_ABY : M_ABX;
            default: mode_o = M_IMP;
          endcase
        end
        2'b00: begin
          unique case (col)
            3'd0: mode_o = (row >= 3'd5) ? M_IMM : M_IMP;
            3'd1: mode_o = M_ZP;
            3'd3: mode_o = M_ABS;
            3'd4: mode_o = M_REL;
            3'd5: mode_o = M_ZPX;
            3'd7: mode_o = M_ABX;
            default: mode_o = M_IMP;
          endcase
        end
        default: mode_o = M_IMP;
      endcase
    end
  end
endmodule

// File: rtl/ea_addr_add.sv
`timescale 1ns/1ps
module ea_addr_add #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2 * DW
) (
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] off_i,
  input  logic          sext_i,
  input  logic          page_wrap_i,
  output logic [AW-1:0] sum_o
);
  localparam int unsigned EXT = AW - DW;

  logic [AW-1:0] off_ext;
  logic [AW-1:0] raw;

  assign off_ext = sext_i ? {{EXT{off_i[DW-1]}}, off_i} : {{EXT{1'b0}}, off_i};
  assign raw     = base_i + off_ext;
  // page wrap keeps the result inside the first 2**DW locations
  assign sum_o   = page_wrap_i ? {{EXT{1'b0}}, raw[DW-1:0]} : raw;
endmodule

// File: rtl/ea_seq_ctrl.sv
`timescale 1ns/1ps
module ea_seq_ctrl
  import ea_seq_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  amode_e        mode_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic [DW-1:0] mem_data_i,
  output logic [AW-1:0] ea_o,
  output logic          imm_o,
  output logic          acc_o,
  output logic [AW-1:0] pc_o,
  output logic          done_o
);
  localparam int unsigned EXT = AW - DW;
  localparam logic [DW-1:0] ONE = DW'(1);

  state_e        state_q, state_d;
  amode_e        mode_q, mode_d;
  logic [AW-1:0] pc_q, pc_d, ptr_q, ptr_d, ea_q, ea_d;
  logic [DW-1:0] x_q, x_d, y_q, y_d, lo_q, lo_d;
  logic          imm_q, imm_d, acc_q, acc_d;

  logic [DW-1:0] idx_sel, zp_off, full_off;
  logic [AW-1:0] zp_sum, full_sum, rel_sum, pc_inc, ptr_inc;
  logic          ptr_zp;

  assign idx_sel  = (mode_q inside {M_ZPY, M_ABY, M_INY}) ? y_q : x_q;
  assign zp_off   = (mode_q inside {M_ZPX, M_ZPY, M_INX}) ? idx_sel : '0;
  assign full_off = (mode_q inside {M_ABX, M_ABY, M_INY}) ? idx_sel : '0;
  assign ptr_zp   = (mode_q != M_IND);

  ea_addr_add #(.DW(DW), .AW(AW)) u_zp (
    .base_i({{EXT{1'b0}}, mem_data_i}), .off_i(zp_off), .sext_i(1'b0),
    .page_wrap_i(1'b1), .sum_o(zp_sum));

  ea_addr_add #(.DW(DW), .AW(AW)) u_full (
    .base_i({mem_data_i, lo_q}), .off_i(full_off), .sext_i(1'b0),
    .page_wrap_i(1'b0), .sum_o(full_sum));

  ea_addr_add #(.DW(DW), .AW(AW)) u_rel (
    .base_i(pc_q), .off_i(mem_data_i), .sext_i(1'b1),
    .page_wrap_i(1'b0), .sum_o(rel_sum));

  ea_addr_add #(.DW(DW), .AW(AW)) u_pc (
    .base_i(pc_q), .off_i(ONE), .sext_i(1'b0),
    .page_wrap_i(1'b0), .sum_o(pc_inc));

  ea_addr_add #(.DW(DW), .AW(AW)) u_ptr (
    .base_i(ptr_q), .off_i(ONE), .sext_i(1'b0),
    .page_wrap_i(ptr_zp), .sum_o(ptr_inc));

  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    pc_d       = pc_q;
    x_d        = x_q;
    y_d        = y_q;
    lo_d       = lo_q;
    ptr_d      = ptr_q;
    ea_d       = ea_q;
    imm_d      = imm_q;
    acc_d      = acc_q;
    mem_rd_o   = 1'b0;
    mem_addr_o = '0;

    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          mode_d  = mode_i;
          pc_d    = pc_i;
          x_d     = x_i;
          y_d     = y_i;
          ea_d    = '0;
          imm_d   = 1'b0;
          acc_d   = (mode_i == M_ACC);
          state_d = (mode_i inside {M_IMP, M_ACC}) ? S_DONE : S_OP0;
        end
      end
      S_OP0: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = pc_q;
        pc_d       = pc_inc;
        state_d    = S_OP1;
      end
      S_OP1: begin
        lo_d = mem_data_i;
        unique case (mode_q)
          M_IMM: begin
            ea_d    = {{EXT{1'b0}}, mem_data_i};
            imm_d   = 1'b1;
            state_d = S_DONE;
          end
          M_ZP, M_ZPX, M_ZPY: begin
            ea_d    = zp_sum;
            state_d = S_DONE;
          end
          M_REL: begin
            ea_d    = rel_sum;
            state_d = S_DONE;
          end
          M_INX, M_INY: begin
            mem_rd_o   = 1'b1;
            mem_addr_o = zp_sum;
            ptr_d      = zp_sum;
            state_d    = S_PTR;
          end
          default: begin
            mem_rd_o   = 1'b1;
            mem_addr_o = pc_q;
            pc_d       = pc_inc;
            state_d    = S_OP2;
          end
        endcase
      end
      S_OP2: begin
        if (mode_q == M_IND) begin
          mem_rd_o   = 1'b1;
          mem_addr_o = {mem_data_i, lo_q};
          ptr_d      = {mem_data_i, lo_q};
          state_d    = S_PTR;
        end else begin
          ea_d    = full_sum;
          state_d = S_DONE;
        end
      end
      S_PTR: begin
        lo_d       = mem_data_i;
        mem_rd_o   = 1'b1;
        mem_addr_o = ptr_inc;
        state_d    = S_TGT;
      end
      S_TGT: begin
        ea_d    = full_sum;
        state_d = S_DONE;
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mode_q  <= M_IMP;
      pc_q    <= '0;
      x_q     <= '0;
      y_q     <= '0;
      lo_q    <= '0;
      ptr_q   <= '0;
      ea_q    <= '0;
      imm_q   <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      pc_q    <= pc_d;
      x_q     <= x_d;
      y_q     <= y_d;
      lo_q    <= lo_d;
      ptr_q   <= ptr_d;
      ea_q    <= ea_d;
      imm_q   <= imm_d;
      acc_q   <= acc_d;
    end
  end

  assign ea_o   = ea_q;
  assign imm_o  = imm_q;
  assign acc_o  = acc_q;
  assign pc_o   = pc_q;
  assign done_o = (state_q == S_DONE);
endmodule

// File: rtl/ea_seq.sv
`timescale 1ns/1ps
module ea_seq
  import ea_seq_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] opcode_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic [DW-1:0] mem_data_i,
  output logic [AW-1:0] ea_o,
  output logic          imm_o,
  output logic          acc_o,
  output logic [AW-1:0] pc_o,
  output logic          done_o
);
  amode_e mode;

  ea_mode_decode u_dec (
    .opcode_i(opcode_i[7:0]),
    .mode_o  (mode)
  );

  ea_seq_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .mode_i(mode),
    .pc_i, .x_i, .y_i,
    .mem_addr_o, .mem_rd_o, .mem_data_i,
    .ea_o, .imm_o, .acc_o, .pc_o, .done_o
  );
endmodule

// File: rtl/ea_seq_chk.sv
`timescale 1ns/1ps
module ea_seq_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2 * DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] pc_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rd_o,
  input logic [AW-1:0] ea_o,
  input logic          imm_o,
  input logic          acc_o,
  input logic [AW-1:0] pc_o,
  input logic          done_o
);
  logic          busy_q;
  logic [AW-1:0] pc_start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      pc_start_q <= '0;
    end else if (!busy_q && start_i) begin
      busy_q     <= 1'b1;
      pc_start_q <= pc_i;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end
  end

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_no_read_at_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_rd_o);

  assert_read_only_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> busy_q);

  assert_flags_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(imm_o && acc_o));

  assert_imm_high_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && imm_o) |-> (ea_o[AW-1:DW] == '0));

  assert_acc_pc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && acc_o) |-> (pc_o == pc_start_q && ea_o == '0));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R12: assert (!done_o && !mem_rd_o && !imm_o && !acc_o
                                      && ea_o == '0 && pc_o == '0 && mem_addr_o == '0);
    end
  end
endmodule

bind ea_seq ea_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i, .rst_ni, .start_i, .pc_i, .mem_addr_o, .mem_rd_o,
  .ea_o, .imm_o, .acc_o, .pc_o, .done_o
);

// File: tb/ea_seq_tb.sv
`timescale 1ns/1ps
module ea_seq_tb;
  localparam int B_IMP = 0, B_ACC = 1, B_IMM = 2, B_ZP = 3, B_ZPX = 4, B_ZPY = 5,
                 B_ABS = 6, B_ABX = 7, B_ABY = 8, B_IND = 9, B_INX = 10, B_INY = 11,
                 B_REL = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] pc = 16'h0000;
  logic [7:0]  xr = 8'h00, yr = 8'h00;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_data = 8'h00;
  logic [15:0] ea, pc_out;
  logic        imm, acc, done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [7:0] ovr [int];

  always #2.5 clk = ~clk;

  ea_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .pc_i(pc), .x_i(xr), .y_i(yr), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_data_i(mem_data), .ea_o(ea), .imm_o(imm), .acc_o(acc),
    .pc_o(pc_out), .done_o(done)
  );

  function automatic logic [7:0] mbyte(int a);
    int k = a & 16'hFFFF;
    logic [15:0] w = k[15:0];
    if (ovr.exists(k)) return ovr[k];
    return w[7:0] ^ w[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) mem_data <= mem_rd ? mbyte(int'(mem_addr)) : 8'hEE;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(logic [7:0] op, int p, logic [7:0] x, logic [7:0] y,
                     int mode, string req, bit hold);
    int rd[$];
    int eea = 0, pcn = p, b, z, q, idx, lat;
    bit eimm = 0, eacc = 0;
    b = mbyte(p);
    idx = (mode == B_ZPY || mode == B_ABY || mode == B_INY) ? int'(y) :
          (mode == B_ZPX || mode == B_ABX || mode == B_INX) ? int'(x) : 0;
    case (mode)
      B_IMP: ;
      B_ACC: eacc = 1;
      B_IMM: begin rd.push_back(p); eea = b; eimm = 1; pcn = p + 1; end
      B_ZP, B_ZPX, B_ZPY: begin rd.push_back(p); eea = (b + idx) & 255; pcn = p + 1; end
      B_REL: begin
        rd.push_back(p); pcn = (p + 1) & 16'hFFFF;
        eea = (pcn + ((b >= 128) ? b - 256 : b)) & 16'hFFFF;
      end
      B_ABS, B_ABX, B_ABY: begin
        rd.push_back(p); rd.push_back((p + 1) & 16'hFFFF);
        eea = (b + 256 * mbyte(p + 1) + idx) & 16'hFFFF; pcn = p + 2;
      end
      B_INX, B_INY: begin
        z = (mode == B_INX) ? ((b + idx) & 255) : b;
        rd.push_back(p); rd.push_back(z); rd.push_back((z + 1) & 255);
        eea = mbyte(z) + 256 * mbyte((z + 1) & 255);
        if (mode == B_INY) eea = (eea + idx) & 16'hFFFF;
        pcn = p + 1;
      end
      B_IND: begin
        q = b + 256 * mbyte(p + 1);
        rd.push_back(p); rd.push_back((p + 1) & 16'hFFFF);
        rd.push_back(q); rd.push_back((q + 1) & 16'hFFFF);
        eea = mbyte(q) + 256 * mbyte((q + 1) & 16'hFFFF); pcn = p + 2;
      end
      default: ;
    endcase
    pcn = pcn & 16'hFFFF;
    lat = (rd.size() == 0) ? 1 : rd.size() + 2;

    @(negedge clk);
    opcode = op; pc = p[15:0]; xr = x; yr = y; start = 1'b1;
    for (int c = 1; c <= lat + 1; c++) begin
      @(negedge clk);
      chk("R10", $sformatf("op %0h rd c%0d", op, c), 32'(mem_rd), 32'(c <= rd.size()));
      if (c <= rd.size())
        chk("R10", $sformatf("op %0h addr c%0d", op, c), 32'(mem_addr), 32'(rd[c-1]));
      chk("R11", $sformatf("op %0h done c%0d", op, c), 32'(done), 32'(c == lat));
      if (c == lat) begin
        chk(req, $sformatf("op %0h ea", op), 32'(ea), 32'(eea));
        chk(req, $sformatf("op %0h pc", op), 32'(pc_out), 32'(pcn));
        chk(req, $sformatf("op %0h imm", op), 32'(imm), 32'(eimm));
        chk(req, $sformatf("op %0h acc", op), 32'(acc), 32'(eacc));
      end
      if (hold && c <= lat) begin
        start = 1'b1; opcode = 8'hA9; pc = 16'hDEAD; xr = 8'h77; yr = 8'h66;
      end else begin
        start = 1'b0;
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "reset done", 32'(done), 0);
    chk("R12", "reset rd", 32'(mem_rd), 0);
    chk("R12", "reset ea", 32'(ea), 0);
    chk("R12", "reset pc", 32'(pc_out), 0);
    chk("R12", "reset flags", 32'({imm, acc}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "idle after reset", 32'({done, mem_rd}), 0);

    // R1 implied and added single-byte opcodes
    run(8'hFC, 16'h1234, 8'h01, 8'h02, B_IMP, "R1", 0);
    run(8'hFF, 16'h2345, 8'h01, 8'h02, B_IMP, "R1", 0);
    run(8'hEA, 16'h0042, 8'h00, 8'h00, B_IMP, "R1", 0);
    run(8'h00, 16'hFFFF, 8'h00, 8'h00, B_IMP, "R1", 0);
    // R2 accumulator forms
    run(8'h0A, 16'h0100, 8'h00, 8'h00, B_ACC, "R2", 0);
    run(8'h6A, 16'h0200, 8'h00, 8'h00, B_ACC, "R2", 0);
    run(8'h4A, 16'h0210, 8'h00, 8'h00, B_ACC, "R2", 0);
    // R3 immediate
    ovr.delete(); ovr[16'h0300] = 8'h37;
    run(8'hA9, 16'h0300, 8'h00, 8'h00, B_IMM, "R3", 0);
    run(8'hA2, 16'h0310, 8'h00, 8'h00, B_IMM, "R3", 0);
    run(8'hC0, 16'h0320, 8'h00, 8'h00, B_IMM, "R3", 0);
    // R4 zero page and its wraps
    ovr.delete(); ovr[16'h0400] = 8'h80; ovr[16'h0410] = 8'hF0; ovr[16'h0420] = 8'hF8;
    run(8'hA5, 16'h0400, 8'h00, 8'h00, B_ZP, "R4", 0);
    run(8'hB5, 16'h0410, 8'h20, 8'h00, B_ZPX, "R4", 0);
    run(8'hB6, 16'h0420, 8'h99, 8'h10, B_ZPY, "R4", 0);
    run(8'h96, 16'h0420, 8'h99, 8'h10, B_ZPY, "R4", 0);
    // R5 absolute and indexed
    ovr.delete();
    ovr[16'h0500] = 8'h34; ovr[16'h0501] = 8'h12;
    ovr[16'h0510] = 8'hF0; ovr[16'h0511] = 8'h12;
    ovr[16'h0520] = 8'hF0; ovr[16'h0521] = 8'hFF;
    run(8'hAD, 16'h0500, 8'h00, 8'h00, B_ABS, "R5", 0);
    run(8'h20, 16'h0500, 8'h00, 8'h00, B_ABS, "R5", 0);
    run(8'hBD, 16'h0510, 8'h20, 8'h00, B_ABX, "R5", 0);
    run(8'hB9, 16'h0520, 8'h00, 8'h20, B_ABY, "R5", 0);
    run(8'hBE, 16'h0510, 8'h05, 8'h30, B_ABY, "R5", 0);
    // R6 pre-indexed indirect with page wrap of the pointer
    ovr.delete(); ovr[16'h0600] = 8'hFE; ovr[16'h00FF] = 8'hCD; ovr[16'h0000] = 8'hAB;
    run(8'hA1, 16'h0600, 8'h01, 8'h00, B_INX, "R6", 0);
    run(8'h81, 16'h0600, 8'h03, 8'h00, B_INX, "R6", 0);
    // R7 post-indexed indirect
    ovr.delete();
    ovr[16'h0610] = 8'h40; ovr[16'h0040] = 8'hF0; ovr[16'h0041] = 8'hFF;
    ovr[16'h0620] = 8'hFF; ovr[16'h00FF] = 8'h11; ovr[16'h0000] = 8'h22;
    run(8'hB1, 16'h0610, 8'h00, 8'h20, B_INY, "R7", 0);
    run(8'hB1, 16'h0620, 8'h00, 8'h00, B_INY, "R7", 0);
    // R8 16-bit pointer indirect
    ovr.delete();
    ovr[16'h0700] = 8'h00; ovr[16'h0701] = 8'h30; ovr[16'h3000] = 8'h78; ovr[16'h3001] = 8'h56;
    ovr[16'h0710] = 8'hFF; ovr[16'h0711] = 8'h30; ovr[16'h30FF] = 8'hEF; ovr[16'h3100] = 8'hBE;
    run(8'h6C, 16'h0700, 8'h00, 8'h00, B_IND, "R8", 0);
    run(8'h6C, 16'h0710, 8'h00, 8'h00, B_IND, "R8", 0);
    // R9 signed branch offsets
    ovr.delete();
    ovr[16'h2000] = 8'hFE; ovr[16'h2100] = 8'h7F; ovr[16'hFFFF] = 8'h05; ovr[16'h0000] = 8'h80;
    run(8'hD0, 16'h2000, 8'h00, 8'h00, B_REL, "R9", 0);
    run(8'hF0, 16'h2100, 8'h00, 8'h00, B_REL, "R9", 0);
    run(8'h10, 16'hFFFF, 8'h00, 8'h00, B_REL, "R9", 0);
    run(8'h90, 16'h0000, 8'h00, 8'h00, B_REL, "R9", 0);
    // R11 start held high while busy must not disturb the sequence
    ovr.delete();
    ovr[16'h0610] = 8'h40; ovr[16'h0040] = 8'hF0; ovr[16'h0041] = 8'hFF;
    run(8'hB1, 16'h0610, 8'h00, 8'h20, B_INY, "R11", 1);
    run(8'hFC, 16'h0800, 8'h00, 8'h00, B_IMP, "R11", 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule